// File: doc/BRIEF.md
# Debug Breakpoint Comparator Unit

This block sits beside a small processor core and watches what the core executes. Every retired instruction shows up as a program-counter value with a valid strobe. A flag beside it marks any instruction that left sequential order: a taken jump, branch, call, return or interrupt entry. Data-memory accesses show up as an address with its own strobe, for reads and writes alike. When a configured condition is seen, the block raises a one-cycle break request towards the debug controller. Alongside the request it gives a vector naming every source that matched.

There are four address slots. Slots 0 and 1 compare only against the program counter. Slots 2 and 3 can also compare against data addresses. A mode bit chooses between two set-ups: four program breakpoints, or three program breakpoints plus slot 3 acting as a data breakpoint. Next to the slots there is a single-step source, which fires on exactly one instruction each time it is armed, and a change-of-flow source. Each source that fires also sets a sticky status bit. Software clears a status bit by writing a one to it.

The execution and data-access inputs are pure observation streams. The block never stalls the core, so those interfaces carry a valid strobe and no ready. Every beat presented with valid high is evaluated in that same cycle. The register port is a plain address / write-data / write-enable port with combinational readback.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset the following hold: all slot addresses read 0, the control register reads 0 (all slots disabled, four-program mode, flow source off, step disarmed), status reads 0, and brk_pulse and brk_src are 0.
- R2: The register map is as follows. Addresses 0 to 3 hold slot addresses. Address 4 is control: bits [3:0] are the slot enables, bit 4 is the mode (1 = slot 3 is a data breakpoint), bit 5 enables the flow source and bit 6 arms single-step. Address 5 is status. Slots 0 and 1 store only 14 bits and read back with bits [15:14] as zero. Slots 2 and 3 store and read back all 16 bits.
- R3: An enabled slot in program use matches in a cycle where insn_valid is high and pc equals the low 14 bits of its stored address. On the next clock edge brk_pulse goes high for one cycle, and brk_src bit i is set for slot i.
- R4: A slot whose enable bit is 0 never produces a match, whatever the pc or data address.
- R5: With mode 0, slot 3 ignores data accesses. With mode 1, slot 3 matches only when dmem_valid is high and dmem_addr equals its 16-bit address, and it ignores the pc. Slots 0 to 2 behave the same in both modes.
- R6: While the step arm bit is set, the first cycle with insn_valid high fires the step source (brk_src bit 4) and clears the arm bit. Cycles without insn_valid do not fire it. A write to control in the same cycle takes priority over the self-clear.
- R7: With the flow enable set, a cycle with insn_valid and flow_change both high fires the flow source (brk_src bit 5). flow_change without insn_valid, or with the enable clear, does nothing.
- R8: brk_src reports every source that matched in the same cycle, with bits [3:0] for the slots, bit 4 for step and bit 5 for flow. It is all zero whenever brk_pulse is low.
- R9: Each status bit at address 5 (same bit map as brk_src) is set when its source fires. It holds until software writes a 1 to that bit position. Bits written as 0 are unchanged, and a new firing in the clearing cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc | input | 14 | Program counter of the executed instruction |
| insn_valid | input | 1 | An instruction executed this cycle |
| flow_change | input | 1 | That instruction broke sequential flow |
| dmem_addr | input | 16 | Data-memory access address |
| dmem_valid | input | 1 | A data access (read or write) occurred this cycle |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Readback of the selected register |
| brk_pulse | output | 1 | One-cycle break request |
| brk_src | output | 6 | Sources that caused the current break request |

## Verification
The bench goes after the data-mode switch of slot 3. A design that switched the wrong slot, or left slot 3 also comparing the pc, would raise breaks on the wrong stream. It checks that single-step fires on exactly one instruction and only on a valid one. A design that failed to self-clear would break on every instruction, and one that ignored the strobe would fire on idle cycles. It also checks that disabled slots stay silent, that several sources report together in one cycle, and that the write-one-to-clear status leaves unwritten bits alone. A faulty clear would lose or keep the wrong sticky bits.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int NUM_SLOTS  = 4;  // total address slots
  localparam int PROG_ONLY  = 2;  // slots below this index never go to data use
  localparam int NUM_SRC    = NUM_SLOTS + 2;
  localparam int SRC_STEP   = NUM_SLOTS;
  localparam int SRC_FLOW   = NUM_SLOTS + 1;
  localparam int ADDR_CTRL  = NUM_SLOTS;
  localparam int ADDR_STAT  = NUM_SLOTS + 1;
  localparam int BIT_MODE   = NUM_SLOTS;
  localparam int BIT_FLOW   = NUM_SLOTS + 1;
  localparam int BIT_STEP   = NUM_SLOTS + 2;
  localparam int DATA_SLOT  = NUM_SLOTS - 1;
endpackage

// File: rtl/dbg_brk_slot.sv
module dbg_brk_slot #(
  parameter int PC_W     = 14,
  parameter int DA_W     = 16,
  parameter bit COMBINED = 1'b0
) (
  input  logic            en,
  input  logic            use_data,
  input  logic [DA_W-1:0] addr,
  input  logic [PC_W-1:0] pc,
  input  logic            insn_valid,
  input  logic [DA_W-1:0] dmem_addr,
  input  logic            dmem_valid,
  output logic            hit
);
  logic prog_hit;
  logic data_hit;

  assign prog_hit = insn_valid && (pc == addr[PC_W-1:0]);

  generate
    if (COMBINED) begin : g_comb
      assign data_hit = dmem_valid && (dmem_addr == addr);
      assign hit      = en && (use_data ? data_hit : prog_hit);
    end else begin : g_prog
      assign data_hit = 1'b0;
      assign hit      = en && prog_hit && !use_data;
    end
  endgenerate
endmodule

// File: rtl/dbg_brk_event.sv
module dbg_brk_event #(
  parameter int NS   = 4,
  parameter int NSRC = NS + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   slot_hits,
  input  logic            step_arm,
  input  logic            flow_en,
  input  logic            insn_valid,
  input  logic            flow_change,
  output logic [NSRC-1:0] src_now,
  output logic            brk_pulse,
  output logic [NSRC-1:0] brk_src
);
  logic step_hit;
  logic flow_hit;

  assign step_hit = step_arm && insn_valid;
  assign flow_hit = flow_en && insn_valid && flow_change;
  assign src_now  = {flow_hit, step_hit, slot_hits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pulse <= 1'b0;
      brk_src   <= '0;
    end else begin
      brk_pulse <= |src_now;
      brk_src   <= src_now;
    end
  end
endmodule

// File: rtl/dbg_brk_regs.sv
module dbg_brk_regs
  import dbg_brk_pkg::*;
#(
  parameter int PC_W = 14,
  parameter int DA_W = 16,
  parameter int RA_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [RA_W-1:0]                reg_addr,
  input  logic [DA_W-1:0]                reg_wdata,
  input  logic                           reg_we,
  input  logic [NUM_SRC-1:0]             src_now,
  output logic [NUM_SLOTS-1:0][DA_W-1:0] slot_addr,
  output logic [NUM_SLOTS-1:0]           slot_en,
  output logic                           mode_data,
  output logic                           flow_en,
  output logic                           step_arm,
  output logic [NUM_SRC-1:0]             status,
  output logic [DA_W-1:0]                reg_rdata
);
  localparam int CTRL_W = NUM_SLOTS + 3;

  logic [DA_W-1:0]   slot_q [NUM_SLOTS];
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic              stat_wr;

  assign ctrl_wr = reg_we && (reg_addr == RA_W'(ADDR_CTRL));
  assign stat_wr = reg_we && (reg_addr == RA_W'(ADDR_STAT));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
      localparam logic [DA_W-1:0] KEEP =
        (gi < PROG_ONLY) ? DA_W'((64'd1 << PC_W) - 64'd1) : {DA_W{1'b1}};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          slot_q[gi] <= '0;
        else if (reg_we && (reg_addr == RA_W'(gi)))
          slot_q[gi] <= reg_wdata & KEEP;
      end
      assign slot_addr[gi] = slot_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= reg_wdata[CTRL_W-1:0];
    end else if (src_now[SRC_STEP]) begin
      ctrl_q[BIT_STEP] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= '0;
    else if (stat_wr)
      status <= (status & ~reg_wdata[NUM_SRC-1:0]) | src_now;
    else
      status <= status | src_now;
  end

  assign slot_en   = ctrl_q[NUM_SLOTS-1:0];
  assign mode_data = ctrl_q[BIT_MODE];
  assign flow_en   = ctrl_q[BIT_FLOW];
  assign step_arm  = ctrl_q[BIT_STEP];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (reg_addr == RA_W'(i)) reg_rdata = slot_q[i];
    if (reg_addr == RA_W'(ADDR_CTRL)) reg_rdata = DA_W'(ctrl_q);
    if (reg_addr == RA_W'(ADDR_STAT)) reg_rdata = DA_W'(status);
  end
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
  import dbg_brk_pkg::*;
#(
  parameter int PC_W = 14,
  parameter int DA_W = 16,
  parameter int RA_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     pc,
  input  logic                insn_valid,
  input  logic                flow_change,
  input  logic [DA_W-1:0]     dmem_addr,
  input  logic                dmem_valid,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [DA_W-1:0]     reg_wdata,
  input  logic                reg_we,
  output logic [DA_W-1:0]     reg_rdata,
  output logic                brk_pulse,
  output logic [NUM_SRC-1:0]  brk_src
);
  logic [NUM_SLOTS-1:0][DA_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0]           slot_en;
  logic [NUM_SLOTS-1:0]           slot_hits;
  logic                           mode_data;
  logic                           flow_en;
  logic                           step_arm;
  logic [NUM_SRC-1:0]             status;
  logic [NUM_SRC-1:0]             src_now;

  dbg_brk_regs #(.PC_W(PC_W), .DA_W(DA_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .src_now(src_now),
    .slot_addr(slot_addr), .slot_en(slot_en), .mode_data(mode_data),
    .flow_en(flow_en), .step_arm(step_arm), .status(status),
    .reg_rdata(reg_rdata)
  );

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_cmp
      dbg_brk_slot #(
        .PC_W(PC_W), .DA_W(DA_W), .COMBINED(gs >= PROG_ONLY)
      ) u_slot (
        .en(slot_en[gs]),
        .use_data(mode_data && (gs == DATA_SLOT)),
        .addr(slot_addr[gs]),
        .pc(pc), .insn_valid(insn_valid),
        .dmem_addr(dmem_addr), .dmem_valid(dmem_valid),
        .hit(slot_hits[gs])
      );
    end
  endgenerate

  dbg_brk_event #(.NS(NUM_SLOTS), .NSRC(NUM_SRC)) u_event (
    .clk(clk), .rst_n(rst_n),
    .slot_hits(slot_hits), .step_arm(step_arm), .flow_en(flow_en),
    .insn_valid(insn_valid), .flow_change(flow_change),
    .src_now(src_now), .brk_pulse(brk_pulse), .brk_src(brk_src)
  );
endmodule

// File: rtl/dbg_brk_check.sv
module dbg_brk_check
  import dbg_brk_pkg::*;
#(
  parameter int DA_W = 16,
  parameter int RA_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 insn_valid,
  input logic                 flow_change,
  input logic                 dmem_valid,
  input logic [RA_W-1:0]      reg_addr,
  input logic [DA_W-1:0]      reg_wdata,
  input logic                 reg_we,
  input logic                 brk_pulse,
  input logic [NUM_SRC-1:0]   brk_src,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic                 mode_data,
  input logic                 step_arm,
  input logic [NUM_SRC-1:0]   status
);
  logic [NUM_SRC-1:0] clr_mask;
  logic               ctrl_wr;
  assign clr_mask = (reg_we && reg_addr == RA_W'(ADDR_STAT)) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign ctrl_wr  = reg_we && (reg_addr == RA_W'(ADDR_CTRL));

  // R8: pulse and source vector agree
  assert_src_zero_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_pulse |-> brk_src == '0);
  assert_pulse_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> brk_src != '0);

  genvar gk;
  generate
    for (gk = 0; gk < NUM_SLOTS; gk++) begin : g_en
      // R4: a reported slot was enabled in the match cycle
      assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_src[gk] |-> $past(slot_en[gk]));
    end
  endgenerate

  // R5: slot 3 follows the stream chosen by the mode
  assert_data_slot_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_src[DATA_SLOT] |-> $past(mode_data ? dmem_valid : insn_valid));

  // R6: step arm drops after firing unless rewritten
  assert_step_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_src[SRC_STEP] && !$past(ctrl_wr)) |-> !step_arm);
  assert_step_needs_insn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_src[SRC_STEP] |-> $past(insn_valid && step_arm));

  // R7: flow source needs a flagged instruction
  assert_flow_needs_insn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_src[SRC_FLOW] |-> $past(insn_valid && flow_change));

  // R9: sticky status, only written ones clear
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~$past(clr_mask)) & ~status) == '0);
  assert_status_covers_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & brk_src) == brk_src);
endmodule

bind dbg_brk_unit dbg_brk_check #(.DA_W(DA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .insn_valid(insn_valid), .flow_change(flow_change), .dmem_valid(dmem_valid),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
  .brk_pulse(brk_pulse), .brk_src(brk_src),
  .slot_en(slot_en), .mode_data(mode_data), .step_arm(step_arm), .status(status)
);

// File: tb/dbg_brk_unit_test.sv
module dbg_brk_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] pc = '0;
  logic        insn_valid = 1'b0;
  logic        flow_change = 1'b0;
  logic [15:0] dmem_addr = '0;
  logic        dmem_valid = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic        brk_pulse;
  logic [5:0]  brk_src;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbg_brk_unit uut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .insn_valid(insn_valid),
    .flow_change(flow_change), .dmem_addr(dmem_addr), .dmem_valid(dmem_valid),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .brk_pulse(brk_pulse), .brk_src(brk_src)
  );

  // vector fields: pc[38:25] iv[24] fl[23] da[22:7] dv[6] exp_src[5:0]
  localparam logic [38:0] VEC [0:8] = '{
    {14'h0100, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000001},
    {14'h0100, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000000},
    {14'h0200, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000010},
    {14'h0300, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000100},
    {14'h0400, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b001000},
    {14'h0401, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000000},
    {14'h0400, 1'b1, 1'b0, 16'h0400, 1'b1, 6'b001000},
    {14'h0123, 1'b0, 1'b0, 16'h0400, 1'b1, 6'b000000},
    {14'h0050, 1'b1, 1'b1, 16'h0000, 1'b0, 6'b000000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // drive one cycle of inputs, then look at the registered outputs
  task automatic step_io(input string req, input logic [13:0] p, input logic iv,
                         input logic fl, input logic [15:0] da, input logic dv,
                         input logic [5:0] exp);
    pc = p; insn_valid = iv; flow_change = fl; dmem_addr = da; dmem_valid = dv;
    @(negedge clk);
    insn_valid = 1'b0; flow_change = 1'b0; dmem_valid = 1'b0;
    check(req, {9'd0, brk_pulse, brk_src}, {9'd0, exp != 6'd0, exp});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 3'd4, 16'h0000);
    rd("R1 status", 3'd5, 16'h0000);
    rd("R1 slot0", 3'd0, 16'h0000);
    rd("R1 slot3", 3'd3, 16'h0000);
    check("R1 outputs", {9'd0, brk_pulse, brk_src}, 16'h0000);

    // R2 readback widths
    wr(3'd0, 16'hFFFF);
    rd("R2 slot0 14-bit", 3'd0, 16'h3FFF);
    wr(3'd2, 16'hABCD);
    rd("R2 slot2 16-bit", 3'd2, 16'hABCD);

    // configure four program slots, all enabled, mode 0
    wr(3'd0, 16'h0100); wr(3'd1, 16'h0200); wr(3'd2, 16'h0300); wr(3'd3, 16'h0400);
    wr(3'd4, 16'h000F);
    rd("R2 ctrl", 3'd4, 16'h000F);

    // R3 / R5 / R7 vector table
    for (int i = 0; i < 9; i++)
      step_io($sformatf("R3 R5 R7 vec%0d", i), VEC[i][38:25], VEC[i][24], VEC[i][23],
              VEC[i][22:7], VEC[i][6], VEC[i][5:0]);
    step_io("R3 one-cycle pulse", 14'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 6'b000000);

    // R4 disabled slot
    wr(3'd4, 16'h000E);
    step_io("R4 disabled slot0", 14'h0100, 1'b1, 1'b0, 16'h0, 1'b0, 6'b000000);
    wr(3'd4, 16'h0000);
    step_io("R4 all disabled", 14'h0200, 1'b1, 1'b0, 16'h0200, 1'b1, 6'b000000);

    // R5 data mode
    wr(3'd4, 16'h001F);
    step_io("R5 data match", 14'h0000, 1'b0, 1'b0, 16'h0400, 1'b1, 6'b001000);
    step_io("R5 pc ignored", 14'h0400, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000000);
    step_io("R5 slot1 program", 14'h0200, 1'b1, 1'b0, 16'h0000, 1'b0, 6'b000010);

    // R6 single step
    wr(3'd4, 16'h0040);
    step_io("R6 idle no fire", 14'h0077, 1'b0, 1'b0, 16'h0, 1'b0, 6'b000000);
    step_io("R6 fire", 14'h0077, 1'b1, 1'b0, 16'h0, 1'b0, 6'b010000);
    step_io("R6 only once", 14'h0078, 1'b1, 1'b0, 16'h0, 1'b0, 6'b000000);
    rd("R6 arm cleared", 3'd4, 16'h0000);

    // R7 flow
    wr(3'd4, 16'h0020);
    step_io("R7 flow fire", 14'h0010, 1'b1, 1'b1, 16'h0, 1'b0, 6'b100000);
    step_io("R7 sequential", 14'h0011, 1'b1, 1'b0, 16'h0, 1'b0, 6'b000000);
    step_io("R7 no insn", 14'h0012, 1'b0, 1'b1, 16'h0, 1'b0, 6'b000000);

    // R8 simultaneous sources
    wr(3'd4, 16'h0061);
    step_io("R8 three sources", 14'h0100, 1'b1, 1'b1, 16'h0, 1'b0, 6'b110001);

    // R9 sticky status and write-one-to-clear
    rd("R9 all sticky", 3'd5, 16'h003F);
    wr(3'd5, 16'h0005);
    rd("R9 partial clear", 3'd5, 16'h003A);
    wr(3'd5, 16'h003A);
    rd("R9 full clear", 3'd5, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule